// File: doc/BRIEF.md
# System Counter with Compare Interrupt

This block keeps a free-running counter that is twice as wide as the register data word. It advances by one on an internal tick, and the tick fires once every `TICK_DIV` cycles of the input clock. One compare channel watches the count. Once the channel is enabled and the count has reached the programmed compare value, a sticky status flag sets. While the mask bit is clear, that flag drives a level interrupt.

Software uses a plain register port with one address, a write strobe and a data word. Reads are combinational.
- The count appears as a low word and a high word. There is no snapshot latch behind them.
- A consistent value comes from reading high, then low, then high again, and retrying when the two high reads differ.
- The compare value is written as two words.
- A control word holds the enable bit, the mask bit and the status flag.
- Clearing the enable bit is the only way to acknowledge the interrupt.

Top module: `sys_counter_cmp`

## Requirements
- R1: The counter advances by exactly one every `TICK_DIV` input clock cycles (default 3) and never changes by any other amount.
- R2: The count low word reads at offset 0x8 and the high word at 0xC. Neither read freezes the other, so a carry from low into high can fall between two reads.
- R3: The compare low word is at 0x10020 and the high word at 0x10024. Only the low `CMP_HI_W` bits of the high word are stored, and the remaining bits read as zero.
- R4: The control word at 0x1002C has bit 0 = enable, bit 1 = mask and bit 2 = status. Status is read-only, so a write to bit 2 has no effect.
- R5: Status sets when enable is 1 and the count is greater than or equal to the compare value. It stays set while enable stays 1, even if the compare value is raised again.
- R6: The interrupt is high exactly when status is 1 and mask is 0.
- R7: Writing 0 to the enable bit clears status, and the interrupt is low after that same clock edge.
- R8: After reset, the count, the compare value and the control word read zero, and the interrupt is low.
- R9: Register writes take effect on the next clock edge. Unmapped offsets read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe for the current offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| irq | output | 1 | Level interrupt, status and not mask |

## Verification
The bench builds the block with `DATA_W = 8`, `CMP_HI_W = 6` and `TICK_DIV = 3`. The narrow data word makes the count 16 bits wide, so the low word wraps into the high word after 256 ticks, which is well inside the run. That makes the torn read reachable: the bench reads high, low and high around the wrap, sees the high word step, and retries to get a consistent value. The narrow stored field of the high compare word also shows the unused bits reading as zero.

// File: rtl/sys_counter_cmp.sv
module sys_counter_cmp #(
  parameter int DATA_W   = 32,
  parameter int CMP_HI_W = 24,
  parameter int TICK_DIV = 3,
  parameter int ADDR_W   = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
  localparam logic [ADDR_W-1:0] OFS_CNT_LO = ADDR_W'(32'h0_0008);
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = ADDR_W'(32'h0_000C);
  localparam logic [ADDR_W-1:0] OFS_CMP_LO = ADDR_W'(32'h1_0020);
  localparam logic [ADDR_W-1:0] OFS_CMP_HI = ADDR_W'(32'h1_0024);
  localparam logic [ADDR_W-1:0] OFS_CTRL   = ADDR_W'(32'h1_002C);

  logic [DIV_W-1:0]    div_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [DATA_W-1:0]   cmp_lo_q;
  logic [CMP_HI_W-1:0] cmp_hi_q;
  logic                en_q, mask_q, stat_q;

  wire tick    = (div_q == DIV_LAST);
  wire wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  wire en_d    = wr_ctrl ? bus_wdata[0] : en_q;
  wire [CNT_W-1:0] cmp_full = CNT_W'({cmp_hi_q, cmp_lo_q});
  wire reached = (cnt_q >= cmp_full);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_lo_q <= '0;
      cmp_hi_q <= '0;
      en_q     <= 1'b0;
      mask_q   <= 1'b0;
      stat_q   <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == OFS_CMP_LO) cmp_lo_q <= bus_wdata;
      if (bus_wr && bus_addr == OFS_CMP_HI) cmp_hi_q <= bus_wdata[CMP_HI_W-1:0];
      if (wr_ctrl) mask_q <= bus_wdata[1];
      en_q   <= en_d;
      stat_q <= en_d && (stat_q || reached);
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_CNT_LO: bus_rdata = cnt_q[DATA_W-1:0];
      OFS_CNT_HI: bus_rdata = cnt_q[CNT_W-1:DATA_W];
      OFS_CMP_LO: bus_rdata = cmp_lo_q;
      OFS_CMP_HI: bus_rdata = DATA_W'(cmp_hi_q);
      OFS_CTRL:   bus_rdata = DATA_W'({stat_q, mask_q, en_q});
      default:    bus_rdata = '0;
    endcase
  end

  assign irq = stat_q && !mask_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1)); // R1
  AST_CNT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(cnt_q)); // R1
  AST_STAT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q |-> en_q); // R5
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !(wr_ctrl && !bus_wdata[0])) |=> stat_q); // R5
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !irq); // R6
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !bus_wdata[0]) |=> (!irq && !stat_q)); // R7
endmodule

// File: tb/test_sys_counter_cmp.sv
module test_sys_counter_cmp;
  localparam int DW = 8;
  localparam int AW = 17;
  localparam logic [AW-1:0] A_LO = 17'h00008, A_HI = 17'h0000C;
  localparam logic [AW-1:0] A_CL = 17'h10020, A_CH = 17'h10024, A_CT = 17'h1002C;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, irq;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  sys_counter_cmp #(.DATA_W(DW), .CMP_HI_W(6), .TICK_DIV(3), .ADDR_W(AW)) i_sys_counter_cmp (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  localparam int NV = 8;
  localparam logic [AW-1:0] V_ADDR [NV] = '{A_CL, A_CH, A_CT, A_CT, A_CT, A_CT, 17'h00004, 17'h10028};
  localparam logic [DW-1:0] V_DATA [NV] = '{8'hA5, 8'hFF, 8'h02, 8'h06, 8'h03, 8'h00, 8'h5A, 8'h77};
  localparam logic [DW-1:0] V_EXP  [NV] = '{8'hA5, 8'h3F, 8'h02, 8'h02, 8'h03, 8'h00, 8'h00, 8'h00};
  localparam string V_TAG [NV] = '{"R3", "R3", "R4", "R4", "R5", "R4", "R9", "R9"};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [DW-1:0] r, c0, c1, h1, h2, l2;
    repeat (3) @(negedge clk);
    // R8 reset state
    rd(A_LO, r); check(r == 0, "R8 cnt lo", r, 0);
    rd(A_CT, r); check(r == 0, "R8 ctrl", r, 0);
    check(irq == 0, "R8 irq", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      wr(V_ADDR[i], V_DATA[i]);
      rd(V_ADDR[i], r);
      check(r == V_EXP[i], V_TAG[i], r, V_EXP[i]);
    end
    rd(A_CL, r); check(r == 8'hA5, "R9 unmapped write left cmp", r, 8'hA5);

    // R1 tick rate
    rd(A_LO, c0); idle(29); rd(A_LO, c1);
    check(8'(c1 - c0) == 10, "R1 rate over 30 cycles", 8'(c1 - c0), 10);
    rd(A_LO, c0); idle(2); rd(A_LO, c1);
    check(8'(c1 - c0) == 1, "R1 rate over 3 cycles", 8'(c1 - c0), 1);

    // R5/R6 compare and interrupt
    rd(A_LO, c0);
    wr(A_CH, 8'h00); wr(A_CL, 8'(c0 + 20)); wr(A_CT, 8'h01);
    check(irq == 0, "R5 no irq before match", irq, 0);
    idle(40);
    check(irq == 0, "R5 no irq early", irq, 0);
    idle(40);
    check(irq == 1, "R6 irq after match", irq, 1);
    rd(A_CT, r); check(r == 8'h05, "R5 status set", r, 8'h05);
    wr(A_CH, 8'h3F);
    check(irq == 1, "R5 status sticky", irq, 1);
    wr(A_CT, 8'h03);
    check(irq == 0, "R6 masked", irq, 0);
    rd(A_CT, r); check(r == 8'h07, "R6 status kept under mask", r, 8'h07);
    wr(A_CT, 8'h01);
    check(irq == 1, "R6 unmasked", irq, 1);
    // R7 acknowledge
    wr(A_CT, 8'h00);
    check(irq == 0, "R7 irq dropped", irq, 0);
    rd(A_CT, r); check(r == 8'h00, "R7 status cleared", r, 0);
    wr(A_CT, 8'h01);
    check(irq == 0, "R7 re-enable below compare", irq, 0);
    wr(A_CT, 8'h00); wr(A_CH, 8'h00); wr(A_CL, 8'h00); wr(A_CT, 8'h01);
    check(irq == 1, "R9 enable takes effect next edge", irq, 1);
    wr(A_CT, 8'h00);

    // R2 carry between reads
    rd(A_LO, r);
    while (r == 8'hFF) rd(A_LO, r);
    while (r != 8'hFF) rd(A_LO, r);
    rd(A_HI, h1); rd(A_LO, r); rd(A_HI, h2);
    check(h2 == 8'(h1 + 1), "R2 carry seen between reads", h2, 8'(h1 + 1));
    rd(A_HI, h1); rd(A_LO, l2); rd(A_HI, h2);
    check(h1 == h2 && l2 < 8'h04, "R2 retry consistent", {h2, l2}, {h1, 8'h00});

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule